// File: doc/BRIEF.md
# Trunk Timing Reference Selector

This block picks the frame-rate reference that drives the second timing loop of a T1/E1 trunk clock generator, and conditions it into a single one-cycle strobe in the system clock domain. There are four candidate sources:

- an external 8 kHz frame signal;
- an internal 8 kHz signal produced by the first timing loop;
- a line-rate clock divided down to frame rate, by either 193 (T1 frame length) or 256 (E1 frame length);
- a 16 kHz signal arriving on a bidirectional frame pin.

A 4-bit mode word chooses the source and the divide ratio. It also decides whether the frame pin listens or drives a frame pulse locked to the chosen reference.

All inputs are asynchronous to the system clock. Each input passes through a synchroniser chain. The frame-style inputs are then edge-detected on their falling edge, and the line clock on its rising edge. The block reports the selected source on a 2-bit indication, so that the loop logic downstream knows what it is locked to. The phase detector and loop filter that consume the strobe live elsewhere.

Top module: `trunk_ref_select`

## Requirements
- R1: While and after reset, until a mode or input edge arrives, `ref_strobe` is 0, `frame_pin_oe` is 0, `frame_pin_out` is 1 and `ref_src` is 0.
- R2: The major mode is the 2-bit value {mode_sel[3], mode_sel[1]}, and it is reported on `ref_src`:
  - 0: external 8 kHz input;
  - 1: internal 8 kHz input;
  - 2: divided line clock;
  - 3: free-run from the frame pin.
- R3: With `ref_src` = 0, `ref_strobe` pulses once per falling edge of `ext_8k_in`, so its period equals that input's period.
- R4: With `ref_src` = 1, `ref_strobe` pulses once per falling edge of `int_8k_in`, for both values of mode_sel[0].
- R5: With `ref_src` = 2, `ref_strobe` pulses once every 193 rising edges of `line_clk_in` when mode_sel[0] = 0, and once every 256 when mode_sel[0] = 1.
- R6: A change of the mode word restarts the divider, so the first strobe in divide mode comes only after a full divide period of line-clock edges. No strobe is issued in the cycle that follows the change being seen.
- R7: With `ref_src` = 3, `ref_strobe` pulses once per falling edge of `frame_pin_in`, and the pin is an input (`frame_pin_oe` = 0) whatever mode_sel[2] is.
- R8: Outside free-run, `frame_pin_oe` equals mode_sel[2]. Outside free-run, `frame_pin_in` has no effect on `ref_strobe`.
- R9: While `frame_pin_oe` is 1, `frame_pin_out` is low exactly in the cycles in which `ref_strobe` is high. While `frame_pin_oe` is 0, `frame_pin_out` is 1.
- R10: A falling edge on `ext_8k_in` shows up on `ref_strobe` after the third rising clock edge that follows it, and not after the second. A new mode word shows up on `ref_src` after three edges in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 4 | Mode word (asynchronous) |
| line_clk_in | input | 1 | Line-rate clock to be divided (asynchronous) |
| ext_8k_in | input | 1 | External 8 kHz frame signal (asynchronous) |
| int_8k_in | input | 1 | Internal 8 kHz signal from the first loop (asynchronous) |
| frame_pin_in | input | 1 | Input side of the bidirectional frame pin |
| ref_strobe | output | 1 | One-cycle reference strobe for the second loop |
| ref_src | output | 2 | Selected source indication |
| frame_pin_oe | output | 1 | Output enable of the frame pin |
| frame_pin_out | output | 1 | Active-low frame pulse driven onto the frame pin |

## Verification
Each timing result has a known delay. A source edge reaches `ref_strobe` on the third clock edge after it, through two synchroniser flops and the output register. A mode word reaches `ref_src` and `frame_pin_oe` with the same three-edge delay. The first strobe of a divide mode arrives one full ratio of line-clock edges after the reload, which follows the mode change by one more cycle.

The bench drives every input on the falling clock edge and samples on the falling edge. It checks the three-edge delay edge by edge, and it waits eight cycles before it reads the mode outputs. Periods are measured only between two strobes that both follow the change, and the first divide-mode strobe is checked against a window derived from those delays.

// File: rtl/trs_pkg.sv
package trs_pkg;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_INT = 2'd1,
    SRC_DIV = 2'd2,
    SRC_PIN = 2'd3
  } src_e;

  localparam int MODE_W = 4;
  localparam int SIG_W  = 4;

  // index of each conditioned input inside the signal vector
  localparam int SIG_LINE = 0;
  localparam int SIG_EXT  = 1;
  localparam int SIG_INT  = 2;
  localparam int SIG_PIN  = 3;

  function automatic src_e major_of(input logic [MODE_W-1:0] m);
    return src_e'({m[3], m[1]});
  endfunction

endpackage

// File: rtl/trs_sync.sv
module trs_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/trs_edge.sv
module trs_edge #(
  parameter int         W         = 4,
  parameter logic [W-1:0] RISE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  output logic [W-1:0] edge_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level;
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_bit
      if (RISE_MASK[g]) begin : g_rise
        assign edge_o[g] = level[g] & ~prev_q[g];
      end else begin : g_fall
        assign edge_o[g] = ~level[g] & prev_q[g];
      end
    end
  endgenerate

endmodule

// File: rtl/trs_divider.sv
module trs_divider #(
  parameter int DIV_A = 193,
  parameter int DIV_B = 256,
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  input  logic enable,
  input  logic sel_b,
  input  logic tick,
  output logic term
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = sel_b ? CNT_W'(DIV_B - 1) : CNT_W'(DIV_A - 1);
  assign term     = enable & tick & (count_q == last_val);

  always_ff @(posedge clk) begin
    if (rst || reload || !enable) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= term ? '0 : count_q + 1'b1;
    end
  end

  // R5: the count never passes the selected terminal value
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
    (!reload && enable) |-> (count_q <= last_val));

  // R6: a reload restarts the count from zero
  a_r6_reload_clears: assert property (@(posedge clk) disable iff (rst)
    reload |=> (count_q == '0));

endmodule

// File: rtl/trs_mode_decode.sv
module trs_mode_decode
  import trs_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output src_e              src,
  output logic              sel_b,
  output logic              pin_oe
);

  always_comb begin
    src    = major_of(mode);
    sel_b  = mode[0];
    pin_oe = mode[2] && (src != SRC_PIN);
  end

endmodule

// File: rtl/trunk_ref_select.sv
module trunk_ref_select
  import trs_pkg::*;
#(
  parameter int DIV_T1      = 193,
  parameter int DIV_E1      = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode_sel,
  input  logic       line_clk_in,
  input  logic       ext_8k_in,
  input  logic       int_8k_in,
  input  logic       frame_pin_in,
  output logic       ref_strobe,
  output logic [1:0] ref_src,
  output logic       frame_pin_oe,
  output logic       frame_pin_out
);

  localparam int DIV_MAX = (DIV_T1 > DIV_E1) ? DIV_T1 : DIV_E1;
  localparam int CNT_W   = $clog2(DIV_MAX);
  localparam logic [SIG_W-1:0] RISE_MASK = SIG_W'(1) << SIG_LINE;

  logic [MODE_W-1:0] mode_s, mode_r;
  logic [SIG_W-1:0]  sig_raw, sig_s, sig_e;
  logic              mode_changed;
  src_e              src_d;
  logic              sel_b_d, oe_d;
  logic              div_term;
  logic              strobe_d;

  trs_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk(clk), .rst(rst), .async_in(mode_sel), .sync_out(mode_s)
  );

  always_comb begin
    sig_raw           = '0;
    sig_raw[SIG_LINE] = line_clk_in;
    sig_raw[SIG_EXT]  = ext_8k_in;
    sig_raw[SIG_INT]  = int_8k_in;
    sig_raw[SIG_PIN]  = frame_pin_in;
  end

  trs_sync #(.W(SIG_W), .STAGES(SYNC_STAGES)) u_sig_sync (
    .clk(clk), .rst(rst), .async_in(sig_raw), .sync_out(sig_s)
  );

  trs_edge #(.W(SIG_W), .RISE_MASK(RISE_MASK)) u_edge (
    .clk(clk), .rst(rst), .level(sig_s), .edge_o(sig_e)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_r <= '0;
    else     mode_r <= mode_s;
  end

  assign mode_changed = (mode_s != mode_r);

  trs_mode_decode u_decode (
    .mode(mode_s), .src(src_d), .sel_b(sel_b_d), .pin_oe(oe_d)
  );

  trs_divider #(.DIV_A(DIV_T1), .DIV_B(DIV_E1), .CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .reload(mode_changed),
    .enable(src_d == SRC_DIV), .sel_b(sel_b_d),
    .tick(sig_e[SIG_LINE]), .term(div_term)
  );

  always_comb begin
    unique case (src_d)
      SRC_EXT: strobe_d = sig_e[SIG_EXT];
      SRC_INT: strobe_d = sig_e[SIG_INT];
      SRC_DIV: strobe_d = div_term;
      SRC_PIN: strobe_d = sig_e[SIG_PIN];
      default: strobe_d = 1'b0;
    endcase
    if (mode_changed) strobe_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_strobe    <= 1'b0;
      ref_src       <= SRC_EXT;
      frame_pin_oe  <= 1'b0;
      frame_pin_out <= 1'b1;
    end else begin
      ref_strobe    <= strobe_d;
      ref_src       <= src_d;
      frame_pin_oe  <= oe_d;
      frame_pin_out <= ~(strobe_d & oe_d);
    end
  end

  // R7: free-run always leaves the pin as an input
  a_r7_free_pin_input: assert property (@(posedge clk) disable iff (rst)
    (ref_src == SRC_PIN) |-> !frame_pin_oe);

  // R9: an undriven pin rests high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
    !frame_pin_oe |-> frame_pin_out);

  // R9: a driven pin mirrors the strobe, active low
  a_r9_pulse_match: assert property (@(posedge clk) disable iff (rst)
    frame_pin_oe |-> (frame_pin_out == !ref_strobe));

  // R6: the cycle after a mode change carries no strobe
  a_r6_change_quiet: assert property (@(posedge clk) disable iff (rst)
    mode_changed |=> !ref_strobe);

  // R3: strobes are single-cycle pulses
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |=> !ref_strobe);

endmodule

// File: tb/trunk_ref_select_bench.sv
module trunk_ref_select_bench;

  localparam int P_EXT  = 60;
  localparam int P_INT  = 84;
  localparam int P_PIN  = 38;
  localparam int P_LINE = 4;
  localparam int DIV1   = 193;
  localparam int DIV2   = 256;
  localparam int MAX_CYC = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] mode_sel = 4'd0;
  logic       line_clk_in = 1'b0;
  logic       ext_8k_in = 1'b1;
  logic       int_8k_in = 1'b1;
  logic       frame_pin_in = 1'b1;
  logic       ref_strobe;
  logic [1:0] ref_src;
  logic       frame_pin_oe;
  logic       frame_pin_out;

  int  cyc = 0;
  int  errors = 0;
  int  checks = 0;
  bit  gen_on = 1'b0;
  bit  done = 1'b0;

  trunk_ref_select u_trunk_ref_select (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .line_clk_in(line_clk_in),
    .ext_8k_in(ext_8k_in), .int_8k_in(int_8k_in), .frame_pin_in(frame_pin_in),
    .ref_strobe(ref_strobe), .ref_src(ref_src),
    .frame_pin_oe(frame_pin_oe), .frame_pin_out(frame_pin_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // free-running sources, driven on the falling clock edge
  initial forever begin
    repeat (P_LINE / 2) @(negedge clk);
    line_clk_in = ~line_clk_in;
  end

  initial begin
    wait (gen_on);
    forever begin
      @(negedge clk) ext_8k_in = 1'b0;
      repeat (5) @(negedge clk);
      ext_8k_in = 1'b1;
      repeat (P_EXT - 6) @(negedge clk);
    end
  end

  initial begin
    wait (gen_on);
    forever begin
      @(negedge clk) int_8k_in = 1'b0;
      repeat (6) @(negedge clk);
      int_8k_in = 1'b1;
      repeat (P_INT - 7) @(negedge clk);
    end
  end

  initial begin
    wait (gen_on);
    forever begin
      @(negedge clk) frame_pin_in = 1'b0;
      repeat (4) @(negedge clk);
      frame_pin_in = 1'b1;
      repeat (P_PIN - 5) @(negedge clk);
    end
  end

  int pin_bad;

  // one negedge sample, tracking the frame-pin output rule (R9)
  task automatic step(input bit exp_oe);
    @(negedge clk);
    if (exp_oe) begin
      if (frame_pin_out !== !ref_strobe) pin_bad++;
    end else begin
      if (frame_pin_out !== 1'b1) pin_bad++;
    end
  endtask

  task automatic wait_strobe(input bit exp_oe, output int t);
    int guard = 0;
    step(exp_oe);
    while (ref_strobe !== 1'b1 && guard < 3000) begin
      step(exp_oe);
      guard++;
    end
    t = cyc;
  endtask

  task automatic run_mode(input logic [3:0] m);
    int major, exp_oe, exp_per, c0, t1, t2, t3, ratio;
    string rq;
    major  = {m[3], m[1]};
    exp_oe = (m[2] && major != 3) ? 1 : 0;
    ratio  = m[0] ? DIV2 : DIV1;
    case (major)
      0: begin exp_per = P_EXT;          rq = "R3"; end
      1: begin exp_per = P_INT;          rq = "R4"; end
      2: begin exp_per = ratio * P_LINE; rq = "R5"; end
      default: begin exp_per = P_PIN;    rq = "R7"; end
    endcase
    @(negedge clk);
    mode_sel = m;
    c0 = cyc;
    repeat (8) @(negedge clk);
    check($sformatf("R2 ref_src mode %0d", m), int'(ref_src), major);
    check($sformatf("R8 frame_pin_oe mode %0d", m), int'(frame_pin_oe), exp_oe);
    pin_bad = 0;
    wait_strobe(exp_oe[0], t1);
    if (major == 2) begin
      checks++;
      if ((t1 - c0) < (ratio - 1) * P_LINE + 2 || (t1 - c0) > ratio * P_LINE + 8) begin
        errors++;
        $display("FAIL R6 first divide strobe mode %0d: actual=%0d expected=%0d..%0d",
                 m, t1 - c0, (ratio - 1) * P_LINE + 2, ratio * P_LINE + 8);
      end
    end
    wait_strobe(exp_oe[0], t2);
    wait_strobe(exp_oe[0], t3);
    check($sformatf("%s period A mode %0d (R8 pin ignored)", rq, m), t2 - t1, exp_per);
    check($sformatf("%s period B mode %0d", rq, m), t3 - t2, exp_per);
    check($sformatf("R9 frame pin output mode %0d mismatches", m), pin_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 ref_strobe in reset", int'(ref_strobe), 0);
    check("R1 frame_pin_oe in reset", int'(frame_pin_oe), 0);
    check("R1 frame_pin_out in reset", int'(frame_pin_out), 1);
    check("R1 ref_src in reset", int'(ref_src), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R1 ref_strobe after reset", int'(ref_strobe), 0);
    check("R1 ref_src after reset", int'(ref_src), 0);

    // R10: source-edge latency on ext_8k_in
    ext_8k_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R10 no strobe after 2 edges", int'(ref_strobe), 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 strobe after 3 edges", int'(ref_strobe), 1);
    @(negedge clk) ext_8k_in = 1'b1;

    // R10: mode latency on ref_src
    mode_sel = 4'b0010;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R10 ref_src held after 2 edges", int'(ref_src), 0);
    @(posedge clk);
    @(negedge clk);
    check("R10 ref_src updated after 3 edges", int'(ref_src), 1);
    mode_sel = 4'd0;
    repeat (6) @(negedge clk);

    gen_on = 1'b1;
    for (int m = 0; m < 16; m++) begin
      run_mode(4'(m));
    end
    // ratio switch inside divide mode, both directions
    run_mode(4'b1001);
    run_mode(4'b1000);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    while (cyc < MAX_CYC) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, MAX_CYC);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule